// File: doc/BRIEF.md
# Multi-Warp Register Scoreboard

This block guards instruction issue in a core that interleaves several warps. It keeps a busy bit for every destination register that has been issued but not yet written back, and an instruction waiting at the issue port is allowed through only when none of its operands is still pending. Registers come in three classes. Integer and floating-point registers are private to each warp, so their busy bits are indexed by warp and register number. Vector registers live in one file shared by every warp, so their busy bits are indexed by register number alone.

The issue port carries a warp id, two integer source indices, three float source indices, two vector source indices, and one destination index per class, each with its own valid bit. `issue_ready` is combinational and depends only on the held fields and the current busy state, with clears from this cycle's writeback already applied. When `issue_valid` and `issue_ready` are both high, the valid destinations become busy on the clock edge. A writeback port carries the retiring instruction's warp id and destinations, and releases their bits. Integer register zero is never tracked.

Top module: `warp_scoreboard`

## Requirements
- R1: After reset every busy bit is clear, so any instruction reports `issue_ready`=1.
- R2: An accepted issue (`issue_valid`&`issue_ready`) marks each valid destination busy. A later instruction with a valid source on that register reports `issue_ready`=0 until the register is written back.
- R3: Integer and float busy bits belong to the issuing warp. A busy integer or float register in warp A does not stall warp B reading the same index.
- R4: Vector busy bits are shared. A busy vector register stalls a reader in any warp.
- R5: Integer register 0 is never marked busy and never stalls as a source. Float and vector register 0 are tracked like any other index.
- R6: A source or destination whose valid bit is 0 has no effect on stalling or marking.
- R7: A writeback clears the busy bits of its valid destinations in the writeback warp (vector bits with no warp). A source retiring in the same cycle does not stall, so `issue_ready` is already 1 in that cycle.
- R8: If an accepted issue and a writeback name the same bit in one cycle, the bit is busy afterwards.
- R9: A stalled instruction, or one with `issue_valid`=0, marks nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction present at issue |
| issue_warp | input | WID_W | Issuing warp |
| issue_isrc_vld | input | 2 | Integer source valid bits |
| issue_isrc0 | input | REG_W | Integer source 0 |
| issue_isrc1 | input | REG_W | Integer source 1 |
| issue_fsrc_vld | input | 3 | Float source valid bits |
| issue_fsrc0 | input | REG_W | Float source 0 |
| issue_fsrc1 | input | REG_W | Float source 1 |
| issue_fsrc2 | input | REG_W | Float source 2 |
| issue_vsrc_vld | input | 2 | Vector source valid bits |
| issue_vsrc0 | input | REG_W | Vector source 0 |
| issue_vsrc1 | input | REG_W | Vector source 1 |
| issue_dst_vld | input | 3 | Destination valid bits {vector, float, integer} |
| issue_idst | input | REG_W | Integer destination |
| issue_fdst | input | REG_W | Float destination |
| issue_vdst | input | REG_W | Vector destination |
| issue_ready | output | 1 | No valid source is pending |
| wb_warp | input | WID_W | Retiring warp |
| wb_dst_vld | input | 3 | Writeback valid bits {vector, float, integer} |
| wb_idst | input | REG_W | Integer register released |
| wb_fdst | input | REG_W | Float register released |
| wb_vdst | input | REG_W | Vector register released |

## Verification
The bench checks that a retiring register frees its dependant within the same cycle. A design that applied clears after the check would hold `issue_ready` low for one cycle. It also checks issue and writeback hitting the same bit together, where a design with the wrong priority would leave a live register looking free. Warp separation is tested both ways: integer and float conflicts across warps must not stall, while vector conflicts must. Integer register 0 is compared against float and vector register 0 to catch a design that exempts index zero in every class or in none.

// File: rtl/warp_scoreboard.sv
module warp_scoreboard #(
  parameter int NUM_WARPS = 4,
  parameter int NUM_REGS  = 32,
  parameter int WID_W     = 2,
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid,
  input  logic [WID_W-1:0] issue_warp,
  input  logic [1:0]       issue_isrc_vld,
  input  logic [REG_W-1:0] issue_isrc0,
  input  logic [REG_W-1:0] issue_isrc1,
  input  logic [2:0]       issue_fsrc_vld,
  input  logic [REG_W-1:0] issue_fsrc0,
  input  logic [REG_W-1:0] issue_fsrc1,
  input  logic [REG_W-1:0] issue_fsrc2,
  input  logic [1:0]       issue_vsrc_vld,
  input  logic [REG_W-1:0] issue_vsrc0,
  input  logic [REG_W-1:0] issue_vsrc1,
  input  logic [2:0]       issue_dst_vld,
  input  logic [REG_W-1:0] issue_idst,
  input  logic [REG_W-1:0] issue_fdst,
  input  logic [REG_W-1:0] issue_vdst,
  output logic             issue_ready,
  input  logic [WID_W-1:0] wb_warp,
  input  logic [2:0]       wb_dst_vld,
  input  logic [REG_W-1:0] wb_idst,
  input  logic [REG_W-1:0] wb_fdst,
  input  logic [REG_W-1:0] wb_vdst
);

  logic [NUM_REGS-1:0] ibusy [NUM_WARPS];
  logic [NUM_REGS-1:0] fbusy [NUM_WARPS];
  logic [NUM_REGS-1:0] vbusy;

  logic [NUM_REGS-1:0] ivis, fvis, vvis;
  logic                accept;

  always_comb begin
    ivis = ibusy[issue_warp];
    fvis = fbusy[issue_warp];
    vvis = vbusy;
    if (wb_warp == issue_warp) begin
      if (wb_dst_vld[0]) ivis[wb_idst] = 1'b0;
      if (wb_dst_vld[1]) fvis[wb_fdst] = 1'b0;
    end
    if (wb_dst_vld[2]) vvis[wb_vdst] = 1'b0;
  end

  wire i0_hit = issue_isrc_vld[0] && issue_isrc0 != '0 && ivis[issue_isrc0];
  wire i1_hit = issue_isrc_vld[1] && issue_isrc1 != '0 && ivis[issue_isrc1];
  wire f0_hit = issue_fsrc_vld[0] && fvis[issue_fsrc0];
  wire f1_hit = issue_fsrc_vld[1] && fvis[issue_fsrc1];
  wire f2_hit = issue_fsrc_vld[2] && fvis[issue_fsrc2];
  wire v0_hit = issue_vsrc_vld[0] && vvis[issue_vsrc0];
  wire v1_hit = issue_vsrc_vld[1] && vvis[issue_vsrc1];

  assign issue_ready = !(i0_hit | i1_hit | f0_hit | f1_hit | f2_hit | v0_hit | v1_hit);
  assign accept = issue_valid && issue_ready;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ibusy[w] <= '0;
        fbusy[w] <= '0;
      end else begin
        if (wb_warp == WID_W'(w) && wb_dst_vld[0]) ibusy[w][wb_idst] <= 1'b0;
        if (wb_warp == WID_W'(w) && wb_dst_vld[1]) fbusy[w][wb_fdst] <= 1'b0;
        if (accept && issue_warp == WID_W'(w) && issue_dst_vld[0] && issue_idst != '0)
          ibusy[w][issue_idst] <= 1'b1;
        if (accept && issue_warp == WID_W'(w) && issue_dst_vld[1])
          fbusy[w][issue_fdst] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vbusy <= '0;
    else begin
      if (wb_dst_vld[2]) vbusy[wb_vdst] <= 1'b0;
      if (accept && issue_dst_vld[2]) vbusy[issue_vdst] <= 1'b1;
    end
  end

  // R5: integer register 0 stays free in every warp
  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_chk
    a_r5_izero_free: assert property (@(posedge clk) disable iff (!rst_n)
      !ibusy[w][0]);
  end

  a_r2_vdst_marked: assert property (@(posedge clk) disable iff (!rst_n)
    accept && issue_dst_vld[2] |=> vbusy[$past(issue_vdst)]);

  a_r8_issue_wins: assert property (@(posedge clk) disable iff (!rst_n)
    accept && issue_dst_vld[1] && wb_dst_vld[1] && wb_warp == issue_warp && wb_fdst == issue_fdst
    |=> fbusy[$past(issue_warp)][$past(issue_fdst)]);

  a_r9_no_mark_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> $countones(vbusy) <= $countones($past(vbusy)));

  a_r7_wb_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wb_dst_vld[2] && !(accept && issue_dst_vld[2] && issue_vdst == wb_vdst)
    |=> !vbusy[$past(wb_vdst)]);

endmodule

// File: tb/test_warp_scoreboard.sv
module test_warp_scoreboard;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 5;
  localparam int WW = 2;

  logic clk = 0, rst_n = 0;
  logic issue_valid;
  logic [WW-1:0] issue_warp, wb_warp;
  logic [1:0] isv, vsv;
  logic [2:0] fsv, dv, wv;
  logic [RW-1:0] i0, i1, f0, f1, f2, v0, v1, id, fd, vd, wi, wf, wvd;
  logic issue_ready;

  int checks = 0, fails = 0;

  warp_scoreboard i_warp_scoreboard (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_warp(issue_warp),
    .issue_isrc_vld(isv), .issue_isrc0(i0), .issue_isrc1(i1),
    .issue_fsrc_vld(fsv), .issue_fsrc0(f0), .issue_fsrc1(f1), .issue_fsrc2(f2),
    .issue_vsrc_vld(vsv), .issue_vsrc0(v0), .issue_vsrc1(v1),
    .issue_dst_vld(dv), .issue_idst(id), .issue_fdst(fd), .issue_vdst(vd),
    .issue_ready(issue_ready), .wb_warp(wb_warp), .wb_dst_vld(wv),
    .wb_idst(wi), .wb_fdst(wf), .wb_vdst(wvd));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD*5000);
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic idle();
    issue_valid = 0; issue_warp = 0; isv = 0; fsv = 0; vsv = 0; dv = 0; wv = 0; wb_warp = 0;
    i0 = 0; i1 = 0; f0 = 0; f1 = 0; f2 = 0; v0 = 0; v1 = 0; id = 0; fd = 0; vd = 0;
    wi = 0; wf = 0; wvd = 0;
  endtask

  // class: 0 int, 1 float, 2 vector
  task automatic mark(input int w, input int cls, input int r);
    idle(); issue_valid = 1; issue_warp = WW'(w); dv[cls] = 1;
    id = RW'(r); fd = RW'(r); vd = RW'(r);
    @(posedge clk); #1; idle();
  endtask

  task automatic release_reg(input int w, input int cls, input int r);
    idle(); wb_warp = WW'(w); wv[cls] = 1; wi = RW'(r); wf = RW'(r); wvd = RW'(r);
    @(posedge clk); #1; idle();
  endtask

  task automatic probe(input int w, input int cls, input int r, input bit exp, input string req);
    idle(); issue_warp = WW'(w);
    if (cls == 0) begin isv = 2'b10; i1 = RW'(r); end
    else if (cls == 1) begin fsv = 3'b100; f2 = RW'(r); end
    else begin vsv = 2'b01; v0 = RW'(r); end
    #1; checks++;
    if (issue_ready !== exp) begin
      fails++; $display("FAIL %s: actual=%b expected=%b", req, issue_ready, exp);
    end
    idle();
  endtask

  // vector table: {mark warp, class, reg, probe warp, expected ready}
  typedef struct packed { logic [1:0] mw; logic [1:0] cls; logic [4:0] r; logic [1:0] pw; logic exp; } vec_t;
  localparam vec_t VEC [8] = '{
    '{2'd0, 2'd0, 5'd3, 2'd0, 1'b0},   // R2 int
    '{2'd1, 2'd0, 5'd3, 2'd2, 1'b1},   // R3 int other warp
    '{2'd2, 2'd1, 5'd7, 2'd2, 1'b0},   // R2 float
    '{2'd2, 2'd1, 5'd7, 2'd3, 1'b1},   // R3 float other warp
    '{2'd0, 2'd2, 5'd9, 2'd3, 1'b0},   // R4 vector shared
    '{2'd3, 2'd0, 5'd0, 2'd3, 1'b1},   // R5 int zero
    '{2'd1, 2'd1, 5'd0, 2'd1, 1'b0},   // R5 float zero tracked
    '{2'd2, 2'd2, 5'd0, 2'd0, 1'b0}    // R5 vector zero tracked
  };

  initial begin
    idle();
    repeat (3) @(posedge clk); #1; rst_n = 1;
    probe(0, 0, 5, 1, "R1");
    probe(3, 2, 31, 1, "R1");

    for (int k = 0; k < 8; k++) begin
      mark(VEC[k].mw, VEC[k].cls, VEC[k].r);
      probe(VEC[k].pw, VEC[k].cls, VEC[k].r, VEC[k].exp, "R2/R3/R4/R5 table");
      release_reg(VEC[k].mw, VEC[k].cls, VEC[k].r);
      probe(VEC[k].mw, VEC[k].cls, VEC[k].r, 1'b1, "R7 release");
    end

    // R6: invalid source ignored, invalid destination marks nothing
    mark(0, 0, 4);
    idle(); isv = 2'b00; i0 = 4; #1; checks++;
    if (issue_ready !== 1) begin fails++; $display("FAIL R6 src: actual=%b expected=1", issue_ready); end
    idle(); issue_valid = 1; fd = 6; dv = 3'b000; @(posedge clk); #1;
    probe(0, 1, 6, 1, "R6 dst");

    // R7: same-cycle release makes dependant ready
    idle(); issue_warp = 0; isv = 2'b01; i0 = 4; wb_warp = 0; wv = 3'b001; wi = 4; #1; checks++;
    if (issue_ready !== 1) begin fails++; $display("FAIL R7 bypass: actual=%b expected=1", issue_ready); end
    @(posedge clk); #1; probe(0, 0, 4, 1, "R7");

    // R7: writeback in wrong warp does not clear
    mark(1, 1, 12); release_reg(2, 1, 12); probe(1, 1, 12, 0, "R7 warp");
    release_reg(1, 1, 12);

    // R8: issue and writeback same bit
    mark(2, 1, 15);
    idle(); issue_valid = 1; issue_warp = 2; dv = 3'b010; fd = 15;
    wb_warp = 2; wv = 3'b010; wf = 15; @(posedge clk); #1;
    probe(2, 1, 15, 0, "R8");
    release_reg(2, 1, 15);

    // R9: stalled instruction marks nothing
    mark(0, 2, 20);
    idle(); issue_valid = 1; vsv = 2'b01; v0 = 20; dv = 3'b100; vd = 21; @(posedge clk); #1;
    probe(0, 2, 21, 1, "R9 stalled");
    idle(); issue_valid = 0; dv = 3'b100; vd = 22; @(posedge clk); #1;
    probe(1, 2, 22, 1, "R9 not valid");

    // R1: reset clears marked state
    mark(1, 0, 8);
    rst_n = 0; @(posedge clk); #1; rst_n = 1;
    probe(1, 2, 20, 1, "R1 reset vec");
    probe(1, 0, 8, 1, "R1 reset int");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule